// File: doc/BRIEF.md
# Status Register Guard for a Serial Flash Controller

This unit keeps the 8-bit status byte of a serial flash device and rules on every write-type request. A command sequencer sends one pulse each time it has received a complete instruction. With the pulse it gives the opcode, the data byte and the target address. The guard updates the write-enable, auto-increment, busy, protection and lock bits. One cycle later it answers each write-type request with a grant or a deny pulse.

Program and erase requests need the write-enable bit, an idle unit and a target outside the protected region. The region is chosen by two protection bits: nothing, the top quarter, the top half, or the whole array. A status write is accepted only when the instruction just before it was the arming instruction. While the write-protect pin is low, the lock bit freezes the protection bits and itself. The sequencer reports the end of each memory operation with a completion pulse. That pulse frees the unit and clears the write-enable bit, following the rules below.

Top module: `sr_guard`

## Requirements
- R1: The status byte is laid out as bit0 busy, bit1 write-enable, bit2 and bit3 the low and high protection bits, bit6 auto-increment mode, and bit7 lock. Bits 5:4 always read 0.
- R2: After reset the status byte is 0Ch, and grant and deny are both 0.
- R3: Opcode 06h sets write-enable. Opcode 04h clears both write-enable and auto-increment mode. Neither opcode raises grant or deny.
- R4: A status write (01h) takes effect only when the instruction event just before it was the arming opcode 50h. The write copies data bit 7 to the lock bit and data bits 3:2 to the protection bits, then grants. Any other status write is denied and changes nothing.
- R5: With wp_n low and the lock bit at 1, a status write is denied. With wp_n low and the lock bit at 0, one write may set the lock and change the protection bits together. With wp_n high, all three bits are writable.
- R6: For an 18-bit address, protection 00 guards nothing, 01 guards addresses with bits 17:16 equal to 11, 10 guards addresses with bit 17 set, and 11 guards every address. Byte program (02h), auto-increment program (AFh), sector erase (20h) and block erase (52h) to a guarded address are denied.
- R7: Chip erase (60h) is granted only when both protection bits are 0.
- R8: A program or erase request is granted only if write-enable is 1 and busy is 0. A grant sets busy. A deny leaves the status byte unchanged.
- R9: A completion pulse while busy clears busy. After a non-auto-increment operation it also clears write-enable. After an auto-increment byte it keeps write-enable, unless done_at_top is 1, in which case it clears both write-enable and auto-increment mode.
- R10: A granted AFh request sets auto-increment mode. While that mode is on, any other program or erase request is denied.
- R11: A status write is denied while busy is 1, even right after the arming opcode.
- R12: When a completion pulse and an instruction event fall in the same cycle, the completion is applied first, and the request is judged against the freed state.
- R13: grant and deny follow the instruction event by one cycle and are never both 1. Other opcodes, such as reads, give neither pulse but cancel the arming.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle pulse: an instruction has been fully received |
| op_code | input | 8 | Opcode of that instruction |
| wr_data | input | 8 | Data byte for a status write |
| tgt_addr | input | ADDR_W (18) | Target address of a program or erase |
| wp_n | input | 1 | Write-protect pin, active low |
| mem_done | input | 1 | One-cycle pulse: the running memory operation has finished |
| done_at_top | input | 1 | With mem_done: auto-increment reached the highest address |
| status | output | 8 | Status byte |
| grant | output | 1 | Request accepted, one cycle after op_valid |
| deny | output | 1 | Request refused, one cycle after op_valid |

## Verification
The main collision is a completion pulse arriving in the same cycle as a new instruction event. The bench forces this with directed cases. In one, a write-enable arrives with the completion of a byte program, and write-enable must end up at 1. In another, a program request arrives with a completion, and the request must be denied because the completion has just cleared write-enable. The random phase issues completions with about one chance in three while busy, so many more such overlaps occur. Each is judged against a bench model that applies the completion before the request.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;

    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_WRDI = 8'h04;
    localparam logic [7:0] OPC_ARM  = 8'h50;
    localparam logic [7:0] OPC_SWR  = 8'h01;
    localparam logic [7:0] OPC_PROG = 8'h02;
    localparam logic [7:0] OPC_AAI  = 8'hAF;
    localparam logic [7:0] OPC_SECT = 8'h20;
    localparam logic [7:0] OPC_BLK  = 8'h52;
    localparam logic [7:0] OPC_CHIP = 8'h60;

    typedef enum logic [3:0] {
        K_OTHER, K_WREN, K_WRDI, K_ARM, K_SWR,
        K_PROG, K_AAI, K_SECT, K_BLK, K_CHIP
    } op_kind_e;

    typedef struct packed {
        logic       lock;
        logic       aai;
        logic [1:0] rsv;
        logic [1:0] bp;
        logic       wel;
        logic       busy;
    } sreg_t;

    localparam sreg_t SREG_RESET = 8'h0C;

    function automatic logic is_mem(op_kind_e k);
        return (k == K_PROG) || (k == K_AAI) || (k == K_SECT) ||
               (k == K_BLK)  || (k == K_CHIP);
    endfunction

    function automatic logic region_hit(logic [1:0] bp, logic [1:0] top2);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return top2 == 2'b11;
            2'b10:   return top2[1];
            default: return 1'b1;
        endcase
    endfunction

    function automatic sreg_t merge_write(sreg_t cur, logic [7:0] d);
        sreg_t r;
        r      = cur;
        r.lock = d[7];
        r.bp   = d[3:2];
        return r;
    endfunction

endpackage

// File: rtl/sr_opdec.sv
module sr_opdec
    import sr_guard_pkg::*;
(
    input  logic [7:0] code,
    output op_kind_e   kind
);
    always_comb begin
        case (code)
            OPC_WREN: kind = K_WREN;
            OPC_WRDI: kind = K_WRDI;
            OPC_ARM:  kind = K_ARM;
            OPC_SWR:  kind = K_SWR;
            OPC_PROG: kind = K_PROG;
            OPC_AAI:  kind = K_AAI;
            OPC_SECT: kind = K_SECT;
            OPC_BLK:  kind = K_BLK;
            OPC_CHIP: kind = K_CHIP;
            default:  kind = K_OTHER;
        endcase
    end
endmodule

// File: rtl/sr_region.sv
module sr_region
    import sr_guard_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        bp,
    input  op_kind_e          kind,
    output logic              blocked
);
    localparam int TOP = ADDR_W - 1;

    logic [1:0] top2;
    assign top2 = addr[TOP -: 2];

    always_comb begin
        if (kind == K_CHIP) blocked = (bp != 2'b00);
        else                blocked = region_hit(bp, top2);
    end
endmodule

// File: rtl/sr_guard.sv
module sr_guard
    import sr_guard_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [7:0]        op_code,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              wp_n,
    input  logic              mem_done,
    input  logic              done_at_top,
    output logic [7:0]        status,
    output logic              grant,
    output logic              deny
);
    sreg_t    st_q, st_d;
    logic     arm_q, arm_d;
    logic     run_aai_q, run_aai_d;
    logic     g_d, d_d;
    op_kind_e kind;
    logic     blocked;

    sr_opdec u_dec (.code(op_code), .kind(kind));

    sr_region #(.ADDR_W(ADDR_W)) u_reg (
        .addr(tgt_addr), .bp(st_q.bp), .kind(kind), .blocked(blocked)
    );

    always_comb begin
        st_d      = st_q;
        arm_d     = arm_q;
        run_aai_d = run_aai_q;
        g_d       = 1'b0;
        d_d       = 1'b0;

        // completion first
        if (mem_done && st_q.busy) begin
            st_d.busy = 1'b0;
            if (!run_aai_q || done_at_top) begin
                st_d.wel = 1'b0;
                if (run_aai_q) st_d.aai = 1'b0;
            end
        end

        if (op_valid) begin
            arm_d = (kind == K_ARM);
            case (kind)
                K_WREN: st_d.wel = 1'b1;
                K_WRDI: begin
                    st_d.wel = 1'b0;
                    st_d.aai = 1'b0;
                end
                K_SWR: begin
                    if (arm_q && !st_d.busy && !(!wp_n && st_q.lock)) begin
                        st_d = merge_write(st_d, wr_data);
                        g_d  = 1'b1;
                    end else begin
                        d_d  = 1'b1;
                    end
                end
                default: begin
                    if (is_mem(kind)) begin
                        if (st_d.wel && !st_d.busy && !blocked &&
                            (kind == K_AAI || !st_d.aai)) begin
                            g_d       = 1'b1;
                            st_d.busy = 1'b1;
                            run_aai_d = (kind == K_AAI);
                            if (kind == K_AAI) st_d.aai = 1'b1;
                        end else begin
                            d_d = 1'b1;
                        end
                    end
                end
            endcase
        end
        st_d.rsv = 2'b00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= SREG_RESET;
            arm_q     <= 1'b0;
            run_aai_q <= 1'b0;
            grant     <= 1'b0;
            deny      <= 1'b0;
        end else begin
            st_q      <= st_d;
            arm_q     <= arm_d;
            run_aai_q <= run_aai_d;
            grant     <= g_d;
            deny      <= d_d;
        end
    end

    assign status = st_q;
endmodule

// File: rtl/sr_guard_chk.sv
module sr_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       op_valid,
    input logic [7:0] op_code,
    input logic       wp_n,
    input logic       mem_done,
    input logic [7:0] status,
    input logic       grant,
    input logic       deny
);
    assert_rsv_zero_R1: assert property (@(posedge clk) disable iff (rst)
        status[5:4] == 2'b00);

    assert_excl_R13: assert property (@(posedge clk) disable iff (rst)
        !(grant && deny));

    assert_reply_needs_event_R13: assert property (@(posedge clk) disable iff (rst)
        (grant || deny) |-> $past(op_valid));

    assert_lock_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (!wp_n && status[7]) |=> (status[7] && $stable(status[3:2])));

    assert_chip_guard_R7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 8'h60 && status[3:2] != 2'b00) |=> !grant);

    assert_busy_from_grant_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(status[0]) |-> grant);

    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (status[0] && !mem_done) |=> status[0]);
endmodule

bind sr_guard sr_guard_chk u_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .wp_n(wp_n), .mem_done(mem_done), .status(status),
    .grant(grant), .deny(deny)
);

// File: tb/sr_guard_tb.sv
`timescale 1ns/1ps
module sr_guard_tb;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          op_valid = 1'b0;
    logic [7:0]    op_code = 8'h00;
    logic [7:0]    wr_data = 8'h00;
    logic [AW-1:0] tgt_addr = '0;
    logic          wp_n = 1'b1;
    logic          mem_done = 1'b0;
    logic          done_at_top = 1'b0;
    logic [7:0]    status;
    logic          grant, deny;

    int vecs = 0;
    int errs = 0;

    // bench model
    logic [7:0] m_st = 8'h0C;
    logic       m_arm = 1'b0;
    logic       m_run = 1'b0;
    logic       m_g = 1'b0;
    logic       m_d = 1'b0;

    always #10 clk = ~clk;

    sr_guard #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .wr_data(wr_data), .tgt_addr(tgt_addr), .wp_n(wp_n),
        .mem_done(mem_done), .done_at_top(done_at_top),
        .status(status), .grant(grant), .deny(deny)
    );

    function automatic logic guarded(logic [1:0] bp, logic [AW-1:0] a, logic chip);
        if (chip) return bp != 2'b00;
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return a[AW-1:AW-2] == 2'b11;
            2'b10:   return a[AW-1];
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic mem_op(logic [7:0] c);
        return c == 8'h02 || c == 8'hAF || c == 8'h20 || c == 8'h52 || c == 8'h60;
    endfunction

    task automatic model_step();
        logic [7:0] s;
        s   = m_st;
        m_g = 1'b0;
        m_d = 1'b0;
        if (mem_done && s[0]) begin
            s[0] = 1'b0;
            if (!m_run || done_at_top) begin
                s[1] = 1'b0;
                if (m_run) s[6] = 1'b0;
            end
        end
        if (op_valid) begin
            if (op_code == 8'h06) s[1] = 1'b1;
            else if (op_code == 8'h04) begin s[1] = 1'b0; s[6] = 1'b0; end
            else if (op_code == 8'h01) begin
                if (m_arm && !s[0] && !(!wp_n && m_st[7])) begin
                    s[7] = wr_data[7]; s[3:2] = wr_data[3:2]; m_g = 1'b1;
                end else m_d = 1'b1;
            end else if (mem_op(op_code)) begin
                if (s[1] && !s[0] && !guarded(m_st[3:2], tgt_addr, op_code == 8'h60) &&
                    (op_code == 8'hAF || !s[6])) begin
                    m_g = 1'b1; s[0] = 1'b1; m_run = (op_code == 8'hAF);
                    if (op_code == 8'hAF) s[6] = 1'b1;
                end else m_d = 1'b1;
            end
            m_arm = (op_code == 8'h50);
        end
        m_st = s;
    endtask

    task automatic check(string tag);
        vecs++;
        if (status !== m_st || grant !== m_g || deny !== m_d) begin
            errs++;
            $display("FAIL %s: status=%h grant=%b deny=%b expected status=%h grant=%b deny=%b",
                     tag, status, grant, deny, m_st, m_g, m_d);
        end
    endtask

    // one cycle: drive at negedge, model, clock, check at next negedge
    task automatic cyc(logic v, logic [7:0] c, logic [7:0] d, logic [AW-1:0] a,
                       logic w, logic md, logic top, string tag);
        op_valid = v; op_code = c; wr_data = d; tgt_addr = a;
        wp_n = w; mem_done = md; done_at_top = top;
        model_step();
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0; mem_done = 1'b0; done_at_top = 1'b0;
        check(tag);
    endtask

    task automatic op(logic [7:0] c, logic [AW-1:0] a, string tag);
        cyc(1'b1, c, 8'h00, a, wp_n, 1'b0, 1'b0, tag);
    endtask

    task automatic swr(logic [7:0] d, logic w, string tag);
        cyc(1'b1, 8'h50, 8'h00, '0, w, 1'b0, 1'b0, tag);
        cyc(1'b1, 8'h01, d, '0, w, 1'b0, 1'b0, tag);
    endtask

    task automatic done(logic top, string tag);
        cyc(1'b0, 8'h00, 8'h00, '0, wp_n, 1'b1, top, tag);
    endtask

    initial begin
        #(200000 * 20);
        errs++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        logic [7:0] codes [10] = '{8'h06, 8'h04, 8'h50, 8'h01, 8'h02,
                                   8'hAF, 8'h20, 8'h52, 8'h60, 8'h05};
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R2 reset");

        op(8'h06, '0, "R3 wren");
        op(8'h04, '0, "R3 wrdi");
        op(8'h06, '0, "R1 wel bit1");
        // R4 arming
        cyc(1'b1, 8'h01, 8'h00, '0, 1'b1, 1'b0, 1'b0, "R4 unarmed write");
        op(8'h50, '0, "R4 arm");
        op(8'h03, '0, "R13 read gives nothing");
        cyc(1'b1, 8'h01, 8'h00, '0, 1'b1, 1'b0, 1'b0, "R4 arm cancelled");
        swr(8'h00, 1'b1, "R4 armed write");
        // R5 lock
        swr(8'h8C, 1'b0, "R5 lock with pin low");
        swr(8'h00, 1'b0, "R5 locked write");
        swr(8'h04, 1'b1, "R5 pin high frees");
        // R6 quarter
        op(8'h06, '0, "R6 wren");
        op(8'h02, 18'h2FFFF, "R6 below quarter");
        done(1'b0, "R9 program done");
        op(8'h06, '0, "R6 wren");
        op(8'h02, 18'h30000, "R6 quarter guarded");
        swr(8'h08, 1'b1, "R6 half");
        op(8'h20, 18'h20000, "R6 half guarded");
        op(8'h20, 18'h1F000, "R6 below half");
        done(1'b0, "R9 erase done");
        op(8'h06, '0, "R7 wren");
        op(8'h60, '0, "R7 chip guarded");
        swr(8'h00, 1'b1, "R7 clear bp");
        op(8'h60, '0, "R7 chip ok");
        // R11 during busy
        swr(8'h0C, 1'b1, "R11 write while busy");
        done(1'b0, "R9 chip done");
        op(8'h02, 18'h00010, "R8 no wel");
        // R12 collisions
        op(8'h06, '0, "R12 wren");
        op(8'h02, 18'h00010, "R12 program");
        cyc(1'b1, 8'h06, 8'h00, '0, 1'b1, 1'b1, 1'b0, "R12 done with wren");
        op(8'h02, 18'h00020, "R12 program 2");
        cyc(1'b1, 8'h02, 8'h00, 18'h30, 1'b1, 1'b1, 1'b0, "R12 done with program");
        // R10 auto-increment
        op(8'h06, '0, "R10 wren");
        op(8'hAF, 18'h00100, "R10 aai start");
        done(1'b0, "R9 aai byte keeps wel");
        op(8'hAF, 18'h00101, "R10 aai next");
        done(1'b0, "R9 aai byte 2");
        op(8'h20, 18'h01000, "R10 other op in aai");
        op(8'h04, '0, "R3 wrdi ends aai");
        op(8'h06, '0, "R10 wren");
        op(8'hAF, 18'h3FFFF, "R10 aai top");
        done(1'b1, "R9 aai at top");

        for (int i = 0; i < 4000; i++) begin
            logic [7:0] c;
            logic       md;
            c  = ($urandom % 16 == 0) ? 8'($urandom) : codes[$urandom % 10];
            md = m_st[0] ? ($urandom % 3 == 0) : ($urandom % 8 == 0);
            cyc($urandom % 4 != 0, c, 8'($urandom), AW'($urandom),
                $urandom % 4 != 0, md, $urandom % 4 == 0, "R13 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule